// File: doc/BRIEF.md
# Domain-Clipped Broadcast Fan-Out Decision

This block decides, for one router of a two-dimensional mesh, which output ports a broadcast head flit is copied to. The mesh is divided into rectangular domains, and each router is told its own coordinates and the inclusive corners of the domain it belongs to. From those values and the input port the head arrived on, the block returns a registered five-bit port mask one clock edge later. Each router in a domain applies the same local rule, and together they build a spanning pattern. Every node of the issuing domain receives exactly one copy, and no copy leaves the domain.

The pattern works as follows. The node that starts the broadcast sends along its column both ways, along its row both ways, and to its own core. A copy that travels along the starting column keeps going straight and also spreads east and west. A copy that travels along a row only keeps going straight. Each port is used only if the neighbour on that side lies inside the domain. A head that enters from a side the domain does not reach, that reaches a router outside its own domain, or that carries an unknown port code is dropped: the mask is zero and an error flag is raised. Several domains can flood at the same time because no copy ever crosses a boundary.

Top module: `bcast_region_fanout`

## Requirements
- R1: The outputs are registered. A head presented with the valid input high appears on the outputs at the next rising clock edge, with the valid output high. A cycle with no head gives valid low, an all-zero mask and no error.
- R2: The mask bits are bit 4 = north, bit 3 = south, bit 2 = east, bit 1 = west, bit 0 = local. The arrival port codes are 0 = local (injected), 1 = west, 2 = east, 3 = south, 4 = north. X grows to the east and Y grows to the north.
- R3: Every accepted head sets the local bit.
- R4: A head injected locally is sent north, south, east and west, each only where that neighbour is inside the domain.
- R5: A head arriving from the south continues north, and one arriving from the north continues south. Both also go east and west where allowed, and neither is ever sent back out of the port it arrived on.
- R6: A head arriving from the west continues only east, and one arriving from the east continues only west. It goes to no Y port.
- R7: No mask bit ever points at a neighbour outside the domain bounds. A one-node domain yields only the local bit.
- R8: The error flag is raised with an all-zero mask when the router is outside its bounds, when the port code is above 4, or when the head arrives from a side whose neighbour is outside the bounds.
- R9: In a mesh of these units joined by ideal links, every node of a domain with a broadcast origin gets exactly one local delivery. Nodes of other domains get none, no unit reports an error, and no node is offered two heads at once, even when several domains start in the same cycle.
- R10: In such a mesh, a node at Manhattan distance d from the origin receives its local copy d+1 cycles after injection. The broadcast completes when the farthest node of the domain is reached.
- R11: After reset the outputs are valid low, mask zero and error low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| head_vld_i | input | 1 | A broadcast head flit is present this cycle |
| head_port_i | input | 3 | Arrival port code of the head |
| node_x_i | input | X_W | X coordinate of this router |
| node_y_i | input | Y_W | Y coordinate of this router |
| dom_xlo_i | input | X_W | Lowest X of the domain (inclusive) |
| dom_xhi_i | input | X_W | Highest X of the domain (inclusive) |
| dom_ylo_i | input | Y_W | Lowest Y of the domain (inclusive) |
| dom_yhi_i | input | Y_W | Highest Y of the domain (inclusive) |
| fan_vld_o | output | 1 | Registered decision is valid |
| fan_mask_o | output | 5 | Output port mask {N, S, E, W, L} |
| fan_err_o | output | 1 | Head rejected; mask forced to zero |

## Verification
The assertions assume that coordinates and bounds are steady while a head is presented, and that at most one head arrives in each cycle. A property that relates a head to the next cycle compares the decision with the inputs as they stood at that head. The bench drives the single unit with one head per two cycles and keeps everything steady in between. The mesh holds the bounds fixed for the whole of a flood. Its ideal links offer each node the union of its neighbours' masks, and any cycle in which two heads land on one node is recorded as a failure rather than passed to the unit.

// File: rtl/bcf_pkg.sv
package bcf_pkg;

    localparam int MASK_W = 5;

    // mask bit positions, equal to the arrival port codes
    localparam int B_L = 0;
    localparam int B_W = 1;
    localparam int B_E = 2;
    localparam int B_S = 3;
    localparam int B_N = 4;

    localparam logic [2:0] P_L = 3'd0;
    localparam logic [2:0] P_W = 3'd1;
    localparam logic [2:0] P_E = 3'd2;
    localparam logic [2:0] P_S = 3'd3;
    localparam logic [2:0] P_N = 3'd4;

    typedef struct packed {
        logic              vld;
        logic              err;
        logic [MASK_W-1:0] mask;
    } fan_state_t;

    // spanning rule: may a head arriving on port p leave through output o
    function automatic logic fwd_allowed(input int o, input logic [2:0] p);
        logic ok;
        ok = 1'b0;
        case (p)
            P_L:     ok = 1'b1;
            P_S:     ok = (o == B_N) || (o == B_E) || (o == B_W);
            P_N:     ok = (o == B_S) || (o == B_E) || (o == B_W);
            P_W:     ok = (o == B_E);
            P_E:     ok = (o == B_W);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/bcf_bound_check.sv
module bcf_bound_check #(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic [X_W-1:0] x_i,
    input  logic [Y_W-1:0] y_i,
    input  logic [X_W-1:0] xlo_i,
    input  logic [X_W-1:0] xhi_i,
    input  logic [Y_W-1:0] ylo_i,
    input  logic [Y_W-1:0] yhi_i,
    // bit 0: this router inside bounds; bits 1..4: neighbour W,E,S,N inside
    output logic [bcf_pkg::MASK_W-1:0] room_o
);
    import bcf_pkg::*;

    logic in_x, in_y, self_in;

    always_comb begin
        in_x    = (x_i >= xlo_i) && (x_i <= xhi_i);
        in_y    = (y_i >= ylo_i) && (y_i <= yhi_i);
        self_in = in_x && in_y;
        room_o       = '0;
        room_o[B_L]  = self_in;
        room_o[B_W]  = self_in && (x_i > xlo_i);
        room_o[B_E]  = self_in && (x_i < xhi_i);
        room_o[B_S]  = self_in && (y_i > ylo_i);
        room_o[B_N]  = self_in && (y_i < yhi_i);
    end

endmodule

// File: rtl/bcf_span_rule.sv
module bcf_span_rule (
    input  logic [2:0]                 port_i,
    input  logic [bcf_pkg::MASK_W-1:0] room_i,
    output logic [bcf_pkg::MASK_W-1:0] mask_o,
    output logic                       err_o
);
    import bcf_pkg::*;

    logic [MASK_W-1:0] fwd;
    logic              bad_code;
    logic              back_open;

    assign fwd[B_L] = 1'b1;

    for (genvar o = 1; o < MASK_W; o++) begin : g_dir
        assign fwd[o] = fwd_allowed(o, port_i) & room_i[o];
    end

    always_comb begin
        bad_code  = 1'b0;
        back_open = 1'b1;
        case (port_i)
            P_L:     back_open = 1'b1;
            P_W:     back_open = room_i[B_W];
            P_E:     back_open = room_i[B_E];
            P_S:     back_open = room_i[B_S];
            P_N:     back_open = room_i[B_N];
            default: bad_code  = 1'b1;
        endcase
        err_o  = bad_code || !room_i[B_L] || !back_open;
        mask_o = err_o ? '0 : fwd;
    end

endmodule

// File: rtl/bcast_region_fanout.sv
module bcast_region_fanout #(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           head_vld_i,
    input  logic [2:0]     head_port_i,
    input  logic [X_W-1:0] node_x_i,
    input  logic [Y_W-1:0] node_y_i,
    input  logic [X_W-1:0] dom_xlo_i,
    input  logic [X_W-1:0] dom_xhi_i,
    input  logic [Y_W-1:0] dom_ylo_i,
    input  logic [Y_W-1:0] dom_yhi_i,
    output logic           fan_vld_o,
    output logic [4:0]     fan_mask_o,
    output logic           fan_err_o
);
    import bcf_pkg::*;

    logic [MASK_W-1:0] room_w;
    logic [MASK_W-1:0] mask_w;
    logic              err_w;
    fan_state_t        st_d, st_q;

    bcf_bound_check #(.X_W(X_W), .Y_W(Y_W)) u_bounds (
        .x_i   (node_x_i),
        .y_i   (node_y_i),
        .xlo_i (dom_xlo_i),
        .xhi_i (dom_xhi_i),
        .ylo_i (dom_ylo_i),
        .yhi_i (dom_yhi_i),
        .room_o(room_w)
    );

    bcf_span_rule u_rule (
        .port_i(head_port_i),
        .room_i(room_w),
        .mask_o(mask_w),
        .err_o (err_w)
    );

    always_comb begin
        st_d = '0;
        if (head_vld_i) begin
            st_d.vld  = 1'b1;
            st_d.err  = err_w;
            st_d.mask = mask_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fan_vld_o  = st_q.vld;
    assign fan_mask_o = st_q.mask;
    assign fan_err_o  = st_q.err;

endmodule

// File: rtl/bcf_checker.sv
module bcf_checker #(
    parameter int X_W = 3,
    parameter int Y_W = 3
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           head_vld_i,
    input logic [2:0]     head_port_i,
    input logic [X_W-1:0] node_x_i,
    input logic [Y_W-1:0] node_y_i,
    input logic [X_W-1:0] dom_xlo_i,
    input logic [X_W-1:0] dom_xhi_i,
    input logic [Y_W-1:0] dom_ylo_i,
    input logic [Y_W-1:0] dom_yhi_i,
    input logic           fan_vld_o,
    input logic [4:0]     fan_mask_o,
    input logic           fan_err_o
);
    import bcf_pkg::*;

    AST_HEAD_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
        head_vld_i |=> fan_vld_o); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fan_vld_o |-> (fan_mask_o == 5'd0 && !fan_err_o)); // R1
    AST_LOCAL_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fan_vld_o && !fan_err_o) |-> fan_mask_o[B_L]); // R3
    AST_NO_BACK_N: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_vld_i && head_port_i == P_N) |=> !fan_mask_o[B_N]); // R5
    AST_NO_BACK_S: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_vld_i && head_port_i == P_S) |=> !fan_mask_o[B_S]); // R5
    AST_ROW_STRAIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_vld_i && (head_port_i == P_W || head_port_i == P_E))
        |=> (!fan_mask_o[B_N] && !fan_mask_o[B_S])); // R6
    AST_EDGE_EAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_vld_i && node_x_i == dom_xhi_i) |=> !fan_mask_o[B_E]); // R7
    AST_EDGE_NORTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_vld_i && node_y_i == dom_yhi_i) |=> !fan_mask_o[B_N]); // R7
    AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fan_err_o |-> (fan_mask_o == 5'd0)); // R8
    AST_OUTSIDE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (head_vld_i && (node_x_i < dom_xlo_i || node_y_i > dom_yhi_i)) |=> fan_err_o); // R8

endmodule

bind bcast_region_fanout bcf_checker #(.X_W(X_W), .Y_W(Y_W)) u_bcf_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .head_vld_i (head_vld_i),
    .head_port_i(head_port_i),
    .node_x_i   (node_x_i),
    .node_y_i   (node_y_i),
    .dom_xlo_i  (dom_xlo_i),
    .dom_xhi_i  (dom_xhi_i),
    .dom_ylo_i  (dom_ylo_i),
    .dom_yhi_i  (dom_yhi_i),
    .fan_vld_o  (fan_vld_o),
    .fan_mask_o (fan_mask_o),
    .fan_err_o  (fan_err_o)
);

// File: tb/bcast_region_fanout_bench.sv
module bcast_region_fanout_bench;

    localparam int NX = 8;
    localparam int NY = 8;
    localparam int NN = NX * NY;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    // ---------------- single unit ----------------
    logic       dv = 1'b0;
    logic [2:0] dport = 3'd0;
    logic [2:0] dx = 3'd0, dy = 3'd0, dxl = 3'd0, dxh = 3'd0, dyl = 3'd0, dyh = 3'd0;
    logic       o_vld, o_err;
    logic [4:0] o_mask;

    bcast_region_fanout #(.X_W(3), .Y_W(3)) u_bcast_region_fanout (
        .clk_i(clk), .rst_ni(rst_n), .head_vld_i(dv), .head_port_i(dport),
        .node_x_i(dx), .node_y_i(dy), .dom_xlo_i(dxl), .dom_xhi_i(dxh),
        .dom_ylo_i(dyl), .dom_yhi_i(dyh),
        .fan_vld_o(o_vld), .fan_mask_o(o_mask), .fan_err_o(o_err));

    // ---------------- mesh of units ----------------
    int sx = NX, sy = NY;
    logic [NN-1:0] mesh_inj = '0;
    logic       in_vld [NN];
    logic [2:0] in_port [NN];
    logic       in_dup [NN];
    logic       m_vld [NN];
    logic       m_err [NN];
    logic [4:0] m_mask [NN];
    logic [2:0] b_xlo [NN], b_xhi [NN], b_ylo [NN], b_yhi [NN];

    always_comb begin
        for (int i = 0; i < NN; i++) begin
            int x, y;
            x = i % NX;
            y = i / NX;
            if (x < sx) begin b_xlo[i] = 3'd0;     b_xhi[i] = 3'(sx - 1); end
            else        begin b_xlo[i] = 3'(sx);   b_xhi[i] = 3'(NX - 1); end
            if (y < sy) begin b_ylo[i] = 3'd0;     b_yhi[i] = 3'(sy - 1); end
            else        begin b_ylo[i] = 3'(sy);   b_yhi[i] = 3'(NY - 1); end
        end
    end

    always_comb begin
        for (int i = 0; i < NN; i++) begin
            int x, y, c, iw, ie, is, in_;
            logic v;
            logic [2:0] p;
            x = i % NX;
            y = i / NX;
            iw = (x > 0) ? i - 1 : i;
            ie = (x < NX - 1) ? i + 1 : i;
            is = (y > 0) ? i - NX : i;
            in_ = (y < NY - 1) ? i + NX : i;
            c = 0; v = 1'b0; p = 3'd0;
            if (mesh_inj[i]) begin v = 1'b1; p = 3'd0; c++; end
            if (x > 0 && m_vld[iw] && m_mask[iw][2])       begin v = 1'b1; p = 3'd1; c++; end
            if (x < NX - 1 && m_vld[ie] && m_mask[ie][1])  begin v = 1'b1; p = 3'd2; c++; end
            if (y > 0 && m_vld[is] && m_mask[is][4])       begin v = 1'b1; p = 3'd3; c++; end
            if (y < NY - 1 && m_vld[in_] && m_mask[in_][3]) begin v = 1'b1; p = 3'd4; c++; end
            in_vld[i]  = v;
            in_port[i] = p;
            in_dup[i]  = (c > 1);
        end
    end

    for (genvar g = 0; g < NN; g++) begin : g_node
        bcast_region_fanout #(.X_W(3), .Y_W(3)) u_node (
            .clk_i(clk), .rst_ni(rst_n), .head_vld_i(in_vld[g]), .head_port_i(in_port[g]),
            .node_x_i(3'(g % NX)), .node_y_i(3'(g / NX)),
            .dom_xlo_i(b_xlo[g]), .dom_xhi_i(b_xhi[g]),
            .dom_ylo_i(b_ylo[g]), .dom_yhi_i(b_yhi[g]),
            .fan_vld_o(m_vld[g]), .fan_mask_o(m_mask[g]), .fan_err_o(m_err[g]));
    end

    // ---------------- reference and checks ----------------
    function automatic logic [5:0] exp_fan(int x, int y, int xl, int xh, int yl, int yh, int p);
        logic [4:0] m;
        if (!(x >= xl && x <= xh && y >= yl && y <= yh) || p > 4) return 6'b100000;
        if ((p == 1 && x == xl) || (p == 2 && x == xh) ||
            (p == 3 && y == yl) || (p == 4 && y == yh)) return 6'b100000;
        m = 5'b00001;
        case (p)
            0: begin
                if (y < yh) m[4] = 1'b1;
                if (y > yl) m[3] = 1'b1;
                if (x < xh) m[2] = 1'b1;
                if (x > xl) m[1] = 1'b1;
            end
            3: begin
                if (y < yh) m[4] = 1'b1;
                if (x < xh) m[2] = 1'b1;
                if (x > xl) m[1] = 1'b1;
            end
            4: begin
                if (y > yl) m[3] = 1'b1;
                if (x < xh) m[2] = 1'b1;
                if (x > xl) m[1] = 1'b1;
            end
            1: if (x < xh) m[2] = 1'b1;
            2: if (x > xl) m[1] = 1'b1;
            default: m = 5'b0;
        endcase
        return {1'b0, m};
    endfunction

    task automatic check_vec(input string tag, input logic [6:0] act, input logic [6:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {vld,err,mask} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int x, input int y, input int xl, input int xh,
                         input int yl, input int yh, input int p, input string tag);
        logic [5:0] e;
        @(negedge clk);
        dv = 1'b1; dport = 3'(p);
        dx = 3'(x); dy = 3'(y); dxl = 3'(xl); dxh = 3'(xh); dyl = 3'(yl); dyh = 3'(yh);
        e = exp_fan(x, y, xl, xh, yl, yh, p);
        @(negedge clk);
        dv = 1'b0;
        check_vec(tag, {o_vld, o_err, o_mask}, {1'b1, e});
    endtask

    function automatic int dom_of(int i);
        return ((i % NX) < sx ? 0 : 1) + (((i / NX) < sy) ? 0 : 2);
    endfunction

    task automatic flood(input int sxv, input int syv, input logic [NN-1:0] org, input string tag);
        int cnt [NN];
        int cyc [NN];
        bit bad;
        sx = sxv; sy = syv; bad = 0;
        for (int i = 0; i < NN; i++) begin cnt[i] = 0; cyc[i] = 0; end
        @(negedge clk);
        mesh_inj = org;
        for (int t = 1; t <= 24; t++) begin
            @(negedge clk);
            if (t == 1) mesh_inj = '0;
            for (int i = 0; i < NN; i++) begin
                if (m_vld[i] && !m_err[i] && m_mask[i][0]) begin cnt[i]++; cyc[i] = t; end
                if (m_err[i] || in_dup[i]) bad = 1;
            end
        end
        for (int i = 0; i < NN; i++) begin
            int o;
            o = -1;
            for (int j = 0; j < NN; j++)
                if (org[j] && dom_of(j) == dom_of(i)) o = j;
            if (o < 0) check_int({tag, " R9 outside-domain deliveries"}, cnt[i], 0);
            else begin
                int d;
                d = ((i % NX) > (o % NX) ? (i % NX) - (o % NX) : (o % NX) - (i % NX)) +
                    ((i / NX) > (o / NX) ? (i / NX) - (o / NX) : (o / NX) - (i / NX));
                check_int({tag, " R9 in-domain deliveries"}, cnt[i], 1);
                check_int({tag, " R10 arrival cycle"}, cyc[i], d + 1);
            end
        end
        check_int({tag, " R9 no error or double offer"}, int'(bad), 0);
    endtask

    function automatic int pick(int lo, int hi);
        return lo + int'($urandom % (hi - lo + 1));
    endfunction

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_vec("R11 reset state", {o_vld, o_err, o_mask}, 7'b0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed single-unit cases
        apply(3, 3, 0, 7, 0, 7, 0, "R2 R4 origin centre");
        @(negedge clk);
        check_vec("R1 idle after head", {o_vld, o_err, o_mask}, 7'b0);
        apply(0, 0, 0, 3, 0, 3, 0, "R4 origin corner");
        apply(2, 1, 0, 3, 0, 3, 3, "R5 from south");
        apply(2, 3, 0, 3, 0, 3, 3, "R5 from south at north edge");
        apply(1, 1, 0, 3, 0, 3, 4, "R5 from north");
        apply(1, 2, 0, 3, 0, 3, 1, "R6 from west");
        apply(3, 2, 0, 3, 0, 3, 1, "R6 from west at east edge");
        apply(1, 2, 0, 3, 0, 3, 2, "R6 from east");
        apply(5, 5, 5, 5, 5, 5, 0, "R7 single-node domain");
        apply(3, 3, 3, 3, 0, 7, 3, "R7 one-column domain");
        apply(4, 2, 0, 3, 0, 3, 0, "R8 router outside bounds");
        apply(2, 2, 0, 3, 0, 3, 6, "R8 bad port code");
        apply(0, 2, 0, 3, 0, 3, 1, "R8 enters across west edge");
        apply(2, 3, 0, 3, 0, 3, 4, "R8 enters across north edge");
        apply(2, 2, 4, 1, 0, 7, 0, "R8 inverted bounds");

        // random single-unit cases
        for (int k = 0; k < 400; k++) begin
            int a, b, c, d;
            a = pick(0, 7); b = pick(0, 7); c = pick(0, 7); d = pick(0, 7);
            apply(pick(0, 7), pick(0, 7), (a < b) ? a : b, (a < b) ? b : a,
                  (c < d) ? c : d, (c < d) ? d : c, pick(0, 7), "R3 R7 random");
        end

        // mesh floods
        begin
            logic [NN-1:0] o;
            o = '0; o[5 * NX + 3] = 1'b1;
            flood(NX, NY, o, "whole mesh");
            o = '0; o[0] = 1'b1; o[1 * NX + 6] = 1'b1; o[5 * NX + 2] = 1'b1; o[7 * NX + 7] = 1'b1;
            flood(4, 4, o, "four quadrants concurrent");
            o = '0; o[2 * NX + 1] = 1'b1; o[6 * NX + 5] = 1'b1;
            flood(4, 4, o, "two of four quadrants");
            for (int r = 0; r < 8; r++) begin
                int rsx, rsy;
                rsx = pick(1, NX); rsy = pick(1, NY);
                o = '0;
                for (int d = 0; d < 4; d++) begin
                    int xl, xh, yl, yh;
                    xl = (d % 2 == 0) ? 0 : rsx;  xh = (d % 2 == 0) ? rsx - 1 : NX - 1;
                    yl = (d / 2 == 0) ? 0 : rsy;  yh = (d / 2 == 0) ? rsy - 1 : NY - 1;
                    if (xl <= xh && yl <= yh && ($urandom % 4) != 0)
                        o[pick(yl, yh) * NX + pick(xl, xh)] = 1'b1;
                end
                flood(rsx, rsy, o, "random split");
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule